// File: doc/BRIEF.md
# UART Receive FIFO with Level Interrupt

This block is the receive half of a UART peripheral. A bit-level receiver, which is not part of this block, hands over one byte per cycle through a valid strobe. The block stores these bytes in an 8-entry FIFO. The processor reads the bytes out through a small register window. Each read of the data register returns the oldest byte and a VALID flag. When VALID is set, the read also removes that byte from the FIFO. Software can therefore drain the FIFO with a loop that stops at the first read that comes back with VALID clear.

The block drives an interrupt request line, and a threshold field in the control register decides when the line rises. The encoding runs backwards compared with a plain level count. The largest setting, 8, raises the request as soon as one byte is waiting. A setting of 0 raises it only when the FIFO is completely full, which suits a handler that empties the FIFO in bulk. The request is a level, so it can feed a level-sensitive input on an interrupt controller. If a byte arrives while the FIFO is full, the byte is discarded and a sticky overrun flag is set.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: Bytes from the receiver are accepted only while the enable bit is set. The enable bit is bit 0 of the control register at address 1. While the bit is clear, incoming bytes leave the FIFO contents and the fill count unchanged.
- R2: When the threshold field holds 8, the interrupt request is high whenever at least one byte is stored. The threshold field is bits 7:4 of the control register at address 1.
- R3: When the threshold field holds 0, the interrupt request is high only while the FIFO holds all 8 bytes.
- R4: A threshold value t from 1 to 7 raises the request when the fill count is at least 8 - t. Any value above 8 behaves the same as 8.
- R5: A read of the data register at address 0 returns the oldest byte in bits 7:0 with VALID in bit 8 set, and it removes that byte from the FIFO. Bytes come out in the order they were accepted.
- R6: A read of the data register while the FIFO is empty returns 0 with VALID clear and changes nothing.
- R7: A byte that arrives while the block is enabled and the FIFO is full is dropped, and the overrun flag is set. The overrun flag is bit 0 of the status register at address 2. The flag stays set until software writes 1 to that bit. Bits 11:8 of the status register hold the fill count.
- R8: A byte that arrives in the same cycle as a data read that pops a byte is accepted, even when the FIFO is full. In that case the fill count stays the same and the FIFO order is kept.
- R9: The interrupt request is a level. It stays high in every cycle in which its condition holds, and it goes low in the cycle after the condition stops holding.
- R10: After reset the FIFO is empty, the block is disabled, the threshold is 0, the overrun flag is clear and the interrupt request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Receiver presents a byte this cycle |
| rxByte | input | 8 | Received byte |
| busAddr | input | 2 | Register select: 0 data, 1 control, 2 status |
| busRd | input | 1 | Read strobe; a read of address 0 pops the FIFO |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as busRd |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a full FIFO that receives a byte in the same cycle as a popping read. Here the byte must be kept and the order preserved, while the same arrival without the read must raise overrun. A directed sequence fills the FIFO with the threshold at 0, pushes one extra byte to trigger overrun, and then issues a read and a push together. The bench then drains the FIFO and compares the byte order. After that, random traffic runs with a push rate well above the read rate. This keeps the FIFO near full while the threshold and enable settings change at random, so every threshold value is met at high occupancy.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam int VALID_BIT = 8;
  localparam int THR_LSB = 4;
  localparam int CNT_LSB = 8;

  typedef struct packed {
    logic push;
    logic pop;
    logic clrOvr;
  } rxStrobes_t;
endpackage

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobes_t st,
  input  logic [7:0] rxByte,
  output logic [7:0] headByte
);
  logic [7:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (st.push) wrPtr <= wrPtr + 1'b1;
      if (st.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (st.push && wrPtr == PTR_W'(i)) mem[i] <= rxByte;
    end
  end

  assign headByte = mem[rdPtr];

  // R8
  ptr_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.push && st.pop) |=> (PTR_W'(wrPtr - rdPtr) == $past(PTR_W'(wrPtr - rdPtr))));
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [1:0]       busAddr,
  input  logic             busRd,
  input  logic             busWr,
  input  logic [31:0]      busWdata,
  output rxStrobes_t       st,
  output logic             rxEnable,
  output logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt,
  output logic             overrun,
  output logic             irq
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic dataRd, popOk, pushOk, dropNow;
  logic [CNT_W-1:0] thrEff, lvl;

  assign dataRd  = busRd && busAddr == ADDR_DATA;
  assign popOk   = dataRd && cnt != '0;
  assign pushOk  = rxValid && rxEnable && (cnt != FULL || popOk);
  assign dropNow = rxValid && rxEnable && !pushOk;

  assign st.push   = pushOk;
  assign st.pop    = popOk;
  assign st.clrOvr = busWr && busAddr == ADDR_STAT && busWdata[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      rxEnable <= 1'b0;
      thr <= '0;
      overrun <= 1'b0;
    end else begin
      case ({pushOk, popOk})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (busWr && busAddr == ADDR_CTRL) begin
        rxEnable <= busWdata[0];
        thr <= busWdata[THR_LSB +: CNT_W];
      end
      if (dropNow) overrun <= 1'b1;
      else if (st.clrOvr) overrun <= 1'b0;
    end
  end

  // inverted encoding: larger setting fires at lower occupancy, never below one byte
  always_comb begin
    thrEff = (thr > FULL) ? FULL : thr;
    lvl = FULL - thrEff;
    if (lvl == '0) lvl = CNT_W'(1);
  end

  assign irq = cnt >= lvl;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN) cnt <= FULL);
  // R3
  full_irq_chk: assert property (@(posedge clk) disable iff (!rstN) cnt == FULL |-> irq);
  // R1
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !dataRd) |=> cnt == $past(cnt));
  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !st.clrOvr) |=> overrun);
  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && cnt == '0 && !rxValid) |=> cnt == '0);
endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic [1:0]  busAddr,
  input  logic        busRd,
  input  logic        busWr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq
);
  rxStrobes_t st;
  logic rxEnable, overrun;
  logic [CNT_W-1:0] thr, cnt;
  logic [7:0] headByte;

  uart_rx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .st(st),
    .rxEnable(rxEnable), .thr(thr), .cnt(cnt), .overrun(overrun), .irq(irq)
  );

  uart_rx_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .rxByte(rxByte), .headByte(headByte)
  );

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_DATA: if (cnt != '0) begin
        busRdata[7:0] = headByte;
        busRdata[VALID_BIT] = 1'b1;
      end
      ADDR_CTRL: begin
        busRdata[0] = rxEnable;
        busRdata[THR_LSB +: CNT_W] = thr;
      end
      ADDR_STAT: begin
        busRdata[0] = overrun;
        busRdata[CNT_LSB +: CNT_W] = cnt;
      end
      default: busRdata = '0;
    endcase
  end
endmodule

// File: tb/tb_uart_rx_fifo_irq.sv
module tb_uart_rx_fifo_irq;
  logic clk = 1'b0, rstN = 1'b0;
  logic rxValid = 1'b0, busRd = 1'b0, busWr = 1'b0;
  logic [7:0] rxByte = '0;
  logic [1:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [7:0] mq[$];
  bit mEn = 1'b0, mOvr = 1'b0;
  int mThr = 0;

  uart_rx_fifo_irq dut (.*);

  always #2 clk = ~clk;

  function automatic bit expIrq(int c, int t);
    int e, l;
    e = (t > 8) ? 8 : t;
    l = 8 - e;
    if (l == 0) l = 1;
    return c >= l;
  endfunction

  function automatic string irqTag(int t);
    if (t >= 8) return "R2";
    if (t == 0) return "R3";
    return "R4";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit rv, logic [7:0] rb, logic [1:0] a, bit rd, bit wr, logic [31:0] wd);
    bit popNow, pushNow;
    @(negedge clk);
    rxValid = rv; rxByte = rb; busAddr = a; busRd = rd; busWr = wr; busWdata = wd;
    #1;
    chk(irqTag(mThr), {31'b0, irq}, {31'b0, expIrq(mq.size(), mThr)});
    if (rd) begin
      case (a)
        2'd0: chk(mq.size() > 0 ? "R5" : "R6", busRdata,
                  mq.size() > 0 ? {23'b0, 1'b1, mq[0]} : 32'h0);
        2'd1: chk("R1", busRdata, {24'b0, 4'(mThr), 3'b0, mEn});
        2'd2: chk("R7", busRdata, {20'b0, 4'(mq.size()), 7'b0, mOvr});
        default: chk("R5", busRdata, 32'h0);
      endcase
    end
    popNow = rd && a == 2'd0 && mq.size() > 0;
    pushNow = rv && mEn && (mq.size() < 8 || popNow);
    @(posedge clk);
    if (popNow) void'(mq.pop_front());
    if (pushNow) mq.push_back(rb);
    if (rv && mEn && !pushNow) mOvr = 1'b1;
    else if (wr && a == 2'd2 && wd[0]) mOvr = 1'b0;
    if (wr && a == 2'd1) begin mEn = wd[0]; mThr = int'(wd[7:4]); end
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask
  task automatic push(logic [7:0] b); step(1, b, 0, 0, 0, 0); endtask
  task automatic rdReg(logic [1:0] a); step(0, 0, a, 1, 0, 0); endtask
  task automatic wrCtrl(bit en, int t); step(0, 0, 2'd1, 0, 1, {24'b0, 4'(t), 3'b0, en}); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R10 reset state
    rdReg(2); rdReg(1); rdReg(0);
    // R1 disabled: bytes ignored
    push(8'hAA); push(8'hBB); rdReg(2);
    // R3 threshold 0, fill to full, R9 level holds
    wrCtrl(1, 0);
    for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
    idle(); idle(); idle();
    // R7 overrun on full
    push(8'hEE); rdReg(2);
    // R8 read and push together while full
    step(1, 8'h77, 2'd0, 1, 0, 0);
    rdReg(2);
    for (int i = 0; i < 9; i++) rdReg(0);
    // R7 sticky then W1C
    rdReg(2); step(0, 0, 2'd2, 0, 1, 32'h1); rdReg(2);
    // R2 threshold 8, R4 sweep intermediate
    for (int t = 0; t <= 10; t++) begin
      wrCtrl(1, t);
      for (int i = 0; i < 8; i++) push(8'(t * 16 + i));
      for (int i = 0; i < 8; i++) rdReg(0);
    end
    // random traffic
    for (int n = 0; n < 6000; n++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 3) wrCtrl($urandom_range(0, 9) != 0, int'($urandom_range(0, 15)));
      else if (r < 5) step(0, 0, 2'd2, $urandom_range(0, 1) == 1, 1, 32'h1);
      else step($urandom_range(0, 99) < 55, 8'($urandom), 2'($urandom_range(0, 2)),
                $urandom_range(0, 99) < 40, 0, 0);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule